// File: doc/BRIEF.md
# Buck Gate-Drive Sequencer

This block is the digital control core of one synchronous buck power stage. From a decoded PWM level (high, low or tri-state) it produces two gate commands, one for the high-side switch and one for the low-side switch. The complementary gate is turned on only after the falling gate reports that it is below its turn-off threshold. A programmable minimum dead time applies to each direction, and a timeout forces the hand-over if that feedback never arrives.

A tri-state PWM level turns both gates off only after a hold-off window, so that a brief passage through the middle band is ignored. Leaving the off state for a valid level costs a short exit delay. When skip mode is selected, the low-side switch behaves like a diode: it conducts only after a high-side pulse and drops out on a zero-cross indication. A high active-low enable, or a supply that is not good, forces both gates low and clears every timer. All delays are counted in cycles of the block clock, and all inputs are synchronous to that clock.

Top module: `buck_gate_seq`

## Requirements
- R1: While `en_n` is 1 both gate outputs are 0 from the next clock edge on, and all timers restart. Once `en_n` returns to 0, a gate turns on only after the exit delay of R10 plus the dead time of R6.
- R2: While `supply_ok` is 0 both gate outputs are 0 from the next clock edge on. Recovery follows the same path as R1.
- R3: `pwm_lvl` encodes 2'b00 as low, 2'b01 as high, and 2'b10 or 2'b11 as tri-state. With `skip_n`=1, high gives `hs_on`=1 with `ls_on`=0, and low gives `hs_on`=0 with `ls_on`=1.
- R4: With `skip_n`=0 the high-side gate follows PWM exactly as in R3. The low-side gate turns on only after a high-side pulse has ended, and never from the both-off state.
- R5: With `skip_n`=0, a 1 on `zero_cross` turns the low-side gate off at the next edge, or stops a pending turn-on. The gate then stays off until the next high-side pulse.
- R6: On a PWM edge the conducting gate turns off at the second clock edge. The other gate turns on only after its partner's `*_below` feedback is 1, and only after at least DT_LS2HS (turning the high side on) or DT_HS2LS (turning the low side on) cycles with both gates off.
- R7: If the feedback stays 0, the waiting gate is forced on MAX_WAIT cycles after the other gate turned off.
- R8: A tri-state level held for TRI_HOLD cycles turns both gates off at the edge after the hold-off expires.
- R9: A tri-state level that returns to a valid level before TRI_HOLD cycles have passed leaves the gates unchanged and restarts the hold-off count.
- R10: From the both-off state, a valid level must be present for TRI_EXIT cycles before the sequencer acts on it.
- R11: `hs_on` and `ls_on` are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 1x tri-state |
| en_n | input | 1 | Active-low enable |
| skip_n | input | 1 | 0 selects skip mode (low-side diode emulation) |
| supply_ok | input | 1 | 1 when the control supply is above its lockout level |
| zero_cross | input | 1 | 1 when reverse current is detected in the low-side switch |
| hs_below | input | 1 | 1 when the high-side gate is below its turn-off threshold |
| ls_below | input | 1 | 1 when the low-side gate is below its turn-off threshold |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
The assertions assume that every input is synchronous to `clk` and that reset is held low at time zero. They make no assumption about the gate feedback or the zero-cross flag, which may toggle at any time. The random stimulus changes the PWM level, the feedback flags, the zero-cross flag, the skip select and brief enable or supply drops only between clock edges. It holds each PWM level for a random number of cycles, so that both short tri-state pulses and full hold-off expiries occur.

// File: rtl/buck_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the buck gate-drive sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package buck_seq_pkg;

    // Qualified drive request after tri-state filtering.
    typedef enum logic [1:0] {
        LVL_LO  = 2'b00,
        LVL_HI  = 2'b01,
        LVL_OFF = 2'b10
    } drive_cmd_t;

    // Sequencer states; the two wait states carry the dead-time interval.
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_HS,
        ST_HS,
        ST_WAIT_LS,
        ST_LS
    } seq_state_t;

endpackage

// File: rtl/cycle_counter.sv
`timescale 1ns/1ps
// Saturating up-counter with synchronous clear.
// Assumes: clear has priority over increment; the count holds at all ones.
module cycle_counter #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] TOP = '1;

    // Count enabled cycles, restarting on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pwm_tri_filter.sv
`timescale 1ns/1ps
// Turns the raw decoded PWM level into a qualified drive request.
// Entering the off request needs TRI_HOLD tri-state cycles. Leaving it
// needs TRI_EXIT valid cycles. Changes between valid levels pass with
// one register of delay.
// Assumes: pwm_lvl is synchronous to clk; TRI_HOLD >= 1 and TRI_EXIT >= 1.
module pwm_tri_filter
    import buck_seq_pkg::*;
#(
    parameter int TRI_HOLD = 16,
    parameter int TRI_EXIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] pwm_lvl,
    output drive_cmd_t cmd
);
    localparam int LONGEST = (TRI_HOLD > TRI_EXIT) ? TRI_HOLD : TRI_EXIT;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(TRI_HOLD - 1);
    localparam logic [CW-1:0] EXIT_LAST = CW'(TRI_EXIT - 1);

    drive_cmd_t    cmd_q, cmd_d;
    logic [CW-1:0] cnt;
    logic          raw_tri, cmd_valid, cnt_inc, cnt_clr;
    drive_cmd_t    raw_cmd;

    assign raw_tri   = pwm_lvl[1];
    assign raw_cmd   = pwm_lvl[0] ? LVL_HI : LVL_LO;
    assign cmd_valid = (cmd_q != LVL_OFF);

    // Next request: hold-off on entering tri-state, exit delay on leaving it.
    always_comb begin
        cmd_d = cmd_q;
        if (!active)
            cmd_d = LVL_OFF;
        else if (cmd_valid) begin
            if (!raw_tri)
                cmd_d = raw_cmd;
            else if (cnt == HOLD_LAST)
                cmd_d = LVL_OFF;
        end else if (!raw_tri && cnt == EXIT_LAST)
            cmd_d = raw_cmd;
    end

    // Count only while a state change is pending; restart on any change.
    assign cnt_inc = (cmd_valid && raw_tri) || (!cmd_valid && !raw_tri);
    assign cnt_clr = !active || !cnt_inc || (cmd_d != cmd_q);

    cycle_counter #(.WIDTH(CW)) delay_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= LVL_OFF;
        else
            cmd_q <= cmd_d;
    end

    assign cmd = cmd_q;

    // R8: the off request only ever follows a tri-state input while enabled.
    p_off_after_tri_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == LVL_OFF && $past(cmd_q) != LVL_OFF && $past(active))
            |-> $past(raw_tri));

    // R10: leaving the off request needs a valid level while enabled.
    p_exit_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != LVL_OFF && $past(cmd_q) == LVL_OFF)
            |-> ($past(!raw_tri) && $past(active)));
endmodule

// File: rtl/gate_fsm.sv
`timescale 1ns/1ps
// Break-before-make sequencer for the two gate commands.
// A wait state sits between the two on states. The waiting gate turns on
// once its partner's below-threshold feedback is seen and the minimum
// dead time has passed, or once MAX_WAIT cycles have passed.
// Skip mode drops the low side on zero-cross.
// Assumes: inputs synchronous to clk; 1 <= DT_* <= MAX_WAIT.
module gate_fsm
    import buck_seq_pkg::*;
#(
    parameter int DT_HS2LS = 2,
    parameter int DT_LS2HS = 1,
    parameter int MAX_WAIT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  drive_cmd_t cmd,
    input  logic       skip_n,
    input  logic       zero_cross,
    input  logic       hs_below,
    input  logic       ls_below,
    output logic       hs_on,
    output logic       ls_on
);
    localparam int WW = $clog2(MAX_WAIT + 1);
    localparam logic [WW-1:0] HS_MIN    = WW'(DT_LS2HS - 1);
    localparam logic [WW-1:0] LS_MIN    = WW'(DT_HS2LS - 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(MAX_WAIT - 1);

    seq_state_t    state_q, state_d;
    logic [WW-1:0] cnt;
    logic          in_wait, hs_go, ls_go, cnt_clr, drop_ls;

    assign in_wait = (state_q == ST_WAIT_HS) || (state_q == ST_WAIT_LS);
    assign hs_go   = (ls_below && cnt >= HS_MIN) || (cnt == WAIT_LAST);
    assign ls_go   = (hs_below && cnt >= LS_MIN) || (cnt == WAIT_LAST);
    assign drop_ls = !skip_n && zero_cross;

    // Next-state decode for the gate sequence.
    always_comb begin
        state_d = state_q;
        if (!active)
            state_d = ST_OFF;
        else begin
            case (state_q)
                ST_OFF: begin
                    if (cmd == LVL_HI)
                        state_d = ST_WAIT_HS;
                    else if (cmd == LVL_LO && skip_n)
                        state_d = ST_WAIT_LS;
                end
                ST_WAIT_HS: begin
                    if (cmd != LVL_HI)
                        state_d = ST_OFF;
                    else if (hs_go)
                        state_d = ST_HS;
                end
                ST_HS: begin
                    if (cmd == LVL_LO)
                        state_d = ST_WAIT_LS;
                    else if (cmd == LVL_OFF)
                        state_d = ST_OFF;
                end
                ST_WAIT_LS: begin
                    if (cmd != LVL_LO || drop_ls)
                        state_d = ST_OFF;
                    else if (ls_go)
                        state_d = ST_LS;
                end
                ST_LS: begin
                    if (cmd == LVL_HI)
                        state_d = ST_WAIT_HS;
                    else if (cmd == LVL_OFF || drop_ls)
                        state_d = ST_OFF;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Dead-time counter runs inside wait states and restarts on each move.
    assign cnt_clr = !active || (state_d != state_q);

    cycle_counter #(.WIDTH(WW)) wait_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (in_wait),
        .count (cnt)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    assign hs_on = (state_q == ST_HS);
    assign ls_on = (state_q == ST_LS);

    // R6: the high side rises only after the low side was already off.
    p_hs_break_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(!ls_on));

    // R6: the low side rises only after the high side was already off.
    p_ls_break_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> $past(!hs_on));

    // R5: in skip mode a zero-cross drops the low side at the next edge.
    p_zero_cross_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && !skip_n && zero_cross) |=> !ls_on);

    // R7: an expired wait with the request still high forces the high side on.
    p_wait_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HS && cnt == WAIT_LAST && active && cmd == LVL_HI)
            |=> hs_on);
endmodule

// File: rtl/buck_gate_seq.sv
`timescale 1ns/1ps
// Top of the buck gate-drive sequencer: tri-state filter, then gate sequencer.
// Assumes: all inputs synchronous to clk; analog sensing lives outside.
module buck_gate_seq
    import buck_seq_pkg::*;
#(
    parameter int TRI_HOLD = 16,
    parameter int TRI_EXIT = 2,
    parameter int DT_HS2LS = 2,
    parameter int DT_LS2HS = 1,
    parameter int MAX_WAIT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic       en_n,
    input  logic       skip_n,
    input  logic       supply_ok,
    input  logic       zero_cross,
    input  logic       hs_below,
    input  logic       ls_below,
    output logic       hs_on,
    output logic       ls_on
);
    logic       active;
    drive_cmd_t cmd;

    assign active = !en_n && supply_ok;

    pwm_tri_filter #(
        .TRI_HOLD (TRI_HOLD),
        .TRI_EXIT (TRI_EXIT)
    ) filter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .pwm_lvl (pwm_lvl),
        .cmd     (cmd)
    );

    gate_fsm #(
        .DT_HS2LS (DT_HS2LS),
        .DT_LS2HS (DT_LS2HS),
        .MAX_WAIT (MAX_WAIT)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .cmd        (cmd),
        .skip_n     (skip_n),
        .zero_cross (zero_cross),
        .hs_below   (hs_below),
        .ls_below   (ls_below),
        .hs_on      (hs_on),
        .ls_on      (ls_on)
    );

    // R11: the two gate commands never overlap.
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R1: a high enable input clears both gates at the next edge.
    p_disable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (!hs_on && !ls_on));

    // R2: a bad supply clears both gates at the next edge.
    p_supply_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_on && !ls_on));
endmodule

// File: tb/buck_gate_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners, then seeded random stimulus.
module buck_gate_seq_tb_top;
    localparam int TRI_HOLD = 16;
    localparam int TRI_EXIT = 2;
    localparam int DT_HS2LS = 2;
    localparam int DT_LS2HS = 1;
    localparam int MAX_WAIT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm = 2'b00;
    logic       en_n = 1'b1;
    logic       skip_n = 1'b1;
    logic       sok = 1'b1;
    logic       zc = 1'b0;
    logic       hsb = 1'b1;
    logic       lsb = 1'b1;
    logic       hs, ls;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    buck_gate_seq #(
        .TRI_HOLD (TRI_HOLD), .TRI_EXIT (TRI_EXIT),
        .DT_HS2LS (DT_HS2LS), .DT_LS2HS (DT_LS2HS), .MAX_WAIT (MAX_WAIT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pwm_lvl (pwm), .en_n (en_n),
        .skip_n (skip_n), .supply_ok (sok), .zero_cross (zc),
        .hs_below (hsb), .ls_below (lsb), .hs_on (hs), .ls_on (ls)
    );

    // Steps from a PWM change, with both gates running, until the new gate is on.
    function automatic int swap_steps(int dt);
        return 2 + dt;
    endfunction

    // Steps from a valid level in the both-off state until the gate is on.
    function automatic int exit_steps(int dt);
        return TRI_EXIT + dt + 1;
    endfunction

    // Steps from a tri-state level until both gates are off.
    function automatic int tri_steps();
        return TRI_HOLD + 1;
    endfunction

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic eh, logic el);
        checks++;
        if (hs !== eh || ls !== el) begin
            failures++;
            $display("FAIL %s: hs/ls=%b%b expected %b%b at %0t", req, hs, ls, eh, el, $time);
        end
    endtask

    // Check "not yet" one step before the expected turn-on, then "on".
    task automatic chk_turn_on(string req, int n, logic eh, logic el);
        step(n - 1);
        chk(req, 1'b0, 1'b0);
        step(1);
        chk(req, eh, el);
    endtask

    initial begin
        int unsigned seed;
        logic p_en_n, p_sok, p_hs;
        seed = $urandom(32'd4242);
        step(3);
        chk("R1 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R1 disabled", 1'b0, 1'b0);

        // R10 startup exit delay, then R3 and R6 switching.
        pwm = 2'b01; en_n = 1'b0;
        chk_turn_on("R10 start", exit_steps(DT_LS2HS), 1'b1, 1'b0);
        pwm = 2'b00;
        step(1); chk("R3 hs holds", 1'b1, 1'b0);
        step(1); chk("R6 hs off first", 1'b0, 1'b0);
        chk_turn_on("R6 min dead", swap_steps(DT_HS2LS) - 2, 1'b0, 1'b1);
        pwm = 2'b01;
        chk_turn_on("R3 hs on", swap_steps(DT_LS2HS), 1'b1, 1'b0);

        // R6: turn-on waits for the below-threshold feedback.
        hsb = 1'b0; pwm = 2'b00;
        step(8); chk("R6 wait feedback", 1'b0, 1'b0);
        hsb = 1'b1;
        step(1); chk("R6 feedback seen", 1'b0, 1'b1);

        // R7: feedback missing, timeout forces the high side on.
        lsb = 1'b0; pwm = 2'b01;
        chk_turn_on("R7 timeout", swap_steps(MAX_WAIT), 1'b1, 1'b0);
        lsb = 1'b1;

        // R8: tri-state hold-off.
        pwm = 2'b10;
        step(tri_steps() - 1); chk("R8 during hold", 1'b1, 1'b0);
        step(1); chk("R8 off", 1'b0, 1'b0);

        // R10: exit delay to the low side.
        pwm = 2'b00;
        chk_turn_on("R10 exit", exit_steps(DT_HS2LS), 1'b0, 1'b1);

        // R9: short tri-state pulses are cancelled and the count restarts.
        pwm = 2'b11;
        step(TRI_HOLD - 6); chk("R9 short tri", 1'b0, 1'b1);
        pwm = 2'b00;
        step(2); chk("R9 back valid", 1'b0, 1'b1);
        pwm = 2'b10;
        step(TRI_HOLD - 4); chk("R9 count restarted", 1'b0, 1'b1);
        pwm = 2'b00;
        step(2);

        // R4 / R5: skip mode.
        skip_n = 1'b0;
        step(2); chk("R4 ls kept", 1'b0, 1'b1);
        pwm = 2'b01;
        chk_turn_on("R4 hs follows", swap_steps(DT_LS2HS), 1'b1, 1'b0);
        pwm = 2'b00;
        chk_turn_on("R4 ls after hs", swap_steps(DT_HS2LS), 1'b0, 1'b1);
        zc = 1'b1;
        step(1); chk("R5 zero cross drop", 1'b0, 1'b0);
        zc = 1'b0;
        step(5); chk("R5 stays off", 1'b0, 1'b0);
        pwm = 2'b01;
        chk_turn_on("R4 hs from off", 3, 1'b1, 1'b0);
        zc = 1'b1; pwm = 2'b00;
        step(6); chk("R5 pending blocked", 1'b0, 1'b0);
        zc = 1'b0; skip_n = 1'b1;
        step(3); chk("R3 sync resumes", 1'b0, 1'b1);

        // R1: enable drop.
        pwm = 2'b01;
        step(swap_steps(DT_LS2HS));
        en_n = 1'b1;
        step(1); chk("R1 disable", 1'b0, 1'b0);
        step(3); chk("R1 held off", 1'b0, 1'b0);
        en_n = 1'b0;
        chk_turn_on("R1 restart", exit_steps(DT_LS2HS), 1'b1, 1'b0);

        // R2: supply drop.
        pwm = 2'b00;
        step(swap_steps(DT_HS2LS));
        chk("R3 ls on", 1'b0, 1'b1);
        sok = 1'b0;
        step(1); chk("R2 supply low", 1'b0, 1'b0);
        sok = 1'b1;
        chk_turn_on("R2 restart", exit_steps(DT_HS2LS), 1'b0, 1'b1);

        // Random phase: invariants R11, R1, R2, R6.
        p_en_n = en_n; p_sok = sok; p_hs = hs;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic c_ls;
            c_ls = ls;
            step(1);
            checks++;
            if (hs && ls) begin
                failures++;
                $display("FAIL R11 overlap: hs/ls=%b%b expected not 11", hs, ls);
            end
            if (p_en_n || !p_sok) begin
                chk(p_en_n ? "R1 random" : "R2 random", 1'b0, 1'b0);
            end
            if (hs && !p_hs && c_ls) begin
                checks++; failures++;
                $display("FAIL R6 random: ls was %b before hs rose, expected 0", c_ls);
            end
            p_hs = hs;
            if ($urandom % 8 == 0) begin
                if ($urandom % 4 == 0)
                    pwm = 2'($urandom % 4);
                else
                    pwm = {1'b0, pwm[0] ^ 1'b1};
            end
            hsb    = ($urandom % 8) != 0;
            lsb    = ($urandom % 8) != 0;
            zc     = ($urandom % 6) == 0;
            if ($urandom % 64 == 0) skip_n = ~skip_n;
            en_n   = ($urandom % 120) == 0;
            sok    = ($urandom % 120) != 0;
            p_en_n = en_n;
            p_sok  = sok;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule